// File: doc/BRIEF.md
# Radix-2 FFT Final Stage with Built-in Reorder

This block closes a 16-point radix-2 FFT whose first stages are two 8-point transforms. One half works on the even-indexed input samples and delivers its eight results in bit-reversed index order. The other half works on the odd-indexed samples and delivers its eight results in natural order. This stage captures the even-half results in a two-bank shift-register store, and the store's read port undoes the index reversal. The odd-half results are consumed as they arrive. A twiddle multiplier and an add/subtract butterfly turn each pair into two spectrum bins. The 16 bins leave the block in natural order, so nothing downstream has to reorder them.

Both inputs use a valid/ready handshake. The even side can fill its second bank while the frame in the first bank is still being combined. The output is a plain valid/last stream with no backpressure. Because the sum and the difference of two 17-bit terms are produced here, the output words are two bits wider than the input words.

Top module: `fft16_last_stage`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_valid and odd_ready are 0 and even_ready is 1.
- R2: Each even frame is eight beats. Beat j (counting from 0) carries the even-half bin whose 3-bit index is j with its bits reversed, so the beats carry bins 0,4,2,6,1,5,3,7. The block pairs each odd bin k with even bin k.
- R3: For k = 0..7 the block emits X[k] = E[k] + P[k], where P[k] = W^k·O[k] and W = exp(−j2π/16). The twiddle is a Q1.14 constant with cos and −sin each rounded to the nearest integer after scaling by 16384. Each part of P is (sum of products + 8192) shifted right arithmetically by 14, kept at 17 bits. X is 18 bits signed. X[k] appears with out_valid in the cycle after odd bin k is accepted.
- R4: Once all eight sums of a frame have been emitted, X[8..15] = E[k] − P[k] follow on eight consecutive cycles. odd_ready is 0 throughout that run.
- R5: out_last is 1 only on the 16th output of a frame, which is X[15].
- R6: odd_ready stays 0 until all eight beats of an even frame have been captured.
- R7: The even store holds two frames. even_ready stays 1 while one frame is being combined and the other bank is free. It falls to 0 when both banks hold frames that have not yet been consumed, and rises again once a frame finishes combining.
- R8: Full-scale inputs (−32768 and 32767 in both parts) produce exact results, with no wrap of the product or of the sum.
- R9: A reset in the middle of an even frame discards the partial frame. The next eight beats form a complete frame on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| even_valid | input | 1 | Even-half bin offered |
| even_ready | output | 1 | Even store can take a beat |
| even_re | input | 16 | Even-half bin, real part |
| even_im | input | 16 | Even-half bin, imaginary part |
| odd_valid | input | 1 | Odd-half bin offered |
| odd_ready | output | 1 | Odd bin is accepted this cycle |
| odd_re | input | 16 | Odd-half bin, real part |
| odd_im | input | 16 | Odd-half bin, imaginary part |
| out_valid | output | 1 | Output bin valid |
| out_last | output | 1 | Last bin of a 16-bin frame |
| out_re | output | 18 | Output bin, real part |
| out_im | output | 18 | Output bin, imaginary part |

## Verification
Several properties are checked on every cycle. out_last never appears without out_valid and always falls on the 16th output. The difference run never has a gap. The store never takes a beat into an occupied bank and never releases an empty one. The rounded twiddle product stays inside the range set by the unit-magnitude twiddle. The arithmetic itself can only be shown by the bench, which compares every bin against values computed from the stated formula. So can the bit-reversed pairing, the gating of the odd side by a complete even frame, the two-frame limit with capture overlapping combination, and the discarding of a partial frame by reset.

// File: rtl/fft16_ls_pkg.sv
package fft16_ls_pkg;

    localparam int DATA_W   = 16;
    localparam int TW_W     = 16;
    localparam int TW_FRAC  = 14;
    localparam int HALF_LOG = 3;
    localparam int HALF_N   = 1 << HALF_LOG;
    localparam int PROD_W   = DATA_W + 1;
    localparam int OUT_W    = DATA_W + 2;
    localparam int ACC_W    = DATA_W + TW_W + 1;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } in_cplx_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] re;
        logic signed [PROD_W-1:0] im;
    } prod_cplx_t;

    typedef struct packed {
        logic signed [OUT_W-1:0] re;
        logic signed [OUT_W-1:0] im;
    } out_cplx_t;

    typedef enum logic {
        PH_SUM  = 1'b0,
        PH_DIFF = 1'b1
    } phase_t;

    function automatic logic [HALF_LOG-1:0] idx_flip(input logic [HALF_LOG-1:0] v);
        logic [HALF_LOG-1:0] r;
        for (int i = 0; i < HALF_LOG; i++) r[i] = v[HALF_LOG-1-i];
        return r;
    endfunction

    // Real part of exp(-j*2*pi*k/16) in Q1.14
    function automatic logic signed [TW_W-1:0] rot_cos(input logic [HALF_LOG-1:0] k);
        case (k)
            3'd0:    return TW_W'(16384);
            3'd1:    return TW_W'(15137);
            3'd2:    return TW_W'(11585);
            3'd3:    return TW_W'(6270);
            3'd4:    return TW_W'(0);
            3'd5:    return TW_W'(-6270);
            3'd6:    return TW_W'(-11585);
            default: return TW_W'(-15137);
        endcase
    endfunction

    // Imaginary part of exp(-j*2*pi*k/16) in Q1.14
    function automatic logic signed [TW_W-1:0] rot_sin(input logic [HALF_LOG-1:0] k);
        case (k)
            3'd0:    return TW_W'(0);
            3'd1:    return TW_W'(-6270);
            3'd2:    return TW_W'(-11585);
            3'd3:    return TW_W'(-15137);
            3'd4:    return TW_W'(-16384);
            3'd5:    return TW_W'(-15137);
            3'd6:    return TW_W'(-11585);
            default: return TW_W'(-6270);
        endcase
    endfunction

endpackage

// File: rtl/fft16_reorder_bank.sv
module fft16_reorder_bank
    import fft16_ls_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  in_cplx_t            wr_data,
    input  logic                rel_en,
    input  logic [HALF_LOG-1:0] rd_idx,
    output logic                wr_ok,
    output logic                rd_ok,
    output in_cplx_t            rd_data
);

    localparam int BANKS = 2;
    localparam logic [HALF_LOG-1:0] FILL_END = HALF_LOG'(HALF_N - 1);

    logic [BANKS-1:0]    full;
    logic                wr_bank;
    logic                rd_bank;
    logic [HALF_LOG-1:0] fill;
    in_cplx_t            bank_rd [BANKS];

    // Each bank is a shift register: after eight beats, arrival j sits in slot j.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        in_cplx_t sreg [HALF_N];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < HALF_N; i++) sreg[i] <= '0;
            end else if (wr_en && (wr_bank == 1'(b))) begin
                for (int i = 0; i < HALF_N - 1; i++) sreg[i] <= sreg[i+1];
                sreg[HALF_N-1] <= wr_data;
            end
        end

        assign bank_rd[b] = sreg[idx_flip(rd_idx)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= '0;
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
            fill    <= '0;
        end else begin
            if (wr_en) begin
                fill <= fill + 1'b1;
                if (fill == FILL_END) begin
                    full[wr_bank] <= 1'b1;
                    wr_bank       <= ~wr_bank;
                end
            end
            if (rel_en) begin
                full[rd_bank] <= 1'b0;
                rd_bank       <= ~rd_bank;
            end
        end
    end

    assign wr_ok   = ~full[wr_bank];
    assign rd_ok   = full[rd_bank];
    assign rd_data = bank_rd[rd_bank];

    // R7: a beat is never written into a bank that still holds a frame
    assert_wr_room_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full[wr_bank])
        else $error("write into occupied bank");

    // R7: only a filled bank is ever released
    assert_rel_full_R7: assert property (@(posedge clk) disable iff (rst)
        rel_en |-> full[rd_bank])
        else $error("release of empty bank");

endmodule

// File: rtl/fft16_twiddle_mul.sv
module fft16_twiddle_mul
    import fft16_ls_pkg::*;
(
    input  logic [HALF_LOG-1:0] k,
    input  in_cplx_t            o,
    output prod_cplx_t          p
);

    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (TW_FRAC - 1);

    logic signed [TW_W-1:0]  wr;
    logic signed [TW_W-1:0]  wi;
    logic signed [ACC_W-1:0] acc_re;
    logic signed [ACC_W-1:0] acc_im;
    logic signed [ACC_W-1:0] sh_re;
    logic signed [ACC_W-1:0] sh_im;

    assign wr = rot_cos(k);
    assign wi = rot_sin(k);

    always_comb begin
        acc_re = ACC_W'($signed(o.re)) * ACC_W'(wr) - ACC_W'($signed(o.im)) * ACC_W'(wi);
        acc_im = ACC_W'($signed(o.re)) * ACC_W'(wi) + ACC_W'($signed(o.im)) * ACC_W'(wr);
        sh_re  = (acc_re + HALF_LSB) >>> TW_FRAC;
        sh_im  = (acc_im + HALF_LSB) >>> TW_FRAC;
        p.re   = sh_re[PROD_W-1:0];
        p.im   = sh_im[PROD_W-1:0];
    end

endmodule

// File: rtl/fft16_butterfly.sv
module fft16_butterfly
    import fft16_ls_pkg::*;
(
    input  in_cplx_t   e,
    input  prod_cplx_t p,
    output out_cplx_t  sum,
    output out_cplx_t  dif
);

    always_comb begin
        sum.re = OUT_W'($signed(e.re)) + OUT_W'($signed(p.re));
        sum.im = OUT_W'($signed(e.im)) + OUT_W'($signed(p.im));
        dif.re = OUT_W'($signed(e.re)) - OUT_W'($signed(p.re));
        dif.im = OUT_W'($signed(e.im)) - OUT_W'($signed(p.im));
    end

endmodule

// File: rtl/fft16_last_stage.sv
module fft16_last_stage
    import fft16_ls_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     even_valid,
    output logic                     even_ready,
    input  logic signed [DATA_W-1:0] even_re,
    input  logic signed [DATA_W-1:0] even_im,
    input  logic                     odd_valid,
    output logic                     odd_ready,
    input  logic signed [DATA_W-1:0] odd_re,
    input  logic signed [DATA_W-1:0] odd_im,
    output logic                     out_valid,
    output logic                     out_last,
    output logic signed [OUT_W-1:0]  out_re,
    output logic signed [OUT_W-1:0]  out_im
);

    localparam logic [HALF_LOG-1:0] LAST_IDX = HALF_LOG'(HALF_N - 1);
    // |W^k * O| <= 2^15 * sqrt(2) for unit-magnitude twiddles
    localparam int PROD_BOUND = 46342;

    phase_t              phase;
    logic [HALF_LOG-1:0] rcnt;
    in_cplx_t            even_in;
    in_cplx_t            odd_in;
    in_cplx_t            e_sel;
    prod_cplx_t          prod;
    out_cplx_t           bf_sum;
    out_cplx_t           bf_dif;
    out_cplx_t           out_q;
    out_cplx_t           hold [HALF_N];
    logic                wr_ok;
    logic                rd_ok;
    logic                ev_acc;
    logic                odd_acc;
    logic                rel_en;

    assign even_in.re = even_re;
    assign even_in.im = even_im;
    assign odd_in.re  = odd_re;
    assign odd_in.im  = odd_im;

    assign even_ready = wr_ok;
    assign ev_acc     = even_valid & wr_ok;
    assign odd_ready  = (phase == PH_SUM) & rd_ok;
    assign odd_acc    = odd_valid & odd_ready;
    assign rel_en     = (phase == PH_DIFF) & (rcnt == LAST_IDX);

    fft16_reorder_bank u_reorder (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ev_acc),
        .wr_data (even_in),
        .rel_en  (rel_en),
        .rd_idx  (rcnt),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .rd_data (e_sel)
    );

    fft16_twiddle_mul u_twiddle (
        .k (rcnt),
        .o (odd_in),
        .p (prod)
    );

    fft16_butterfly u_bfly (
        .e   (e_sel),
        .p   (prod),
        .sum (bf_sum),
        .dif (bf_dif)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_SUM;
            rcnt      <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_q     <= '0;
            for (int i = 0; i < HALF_N; i++) hold[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            case (phase)
                PH_SUM: begin
                    if (odd_acc) begin
                        out_valid  <= 1'b1;
                        out_q      <= bf_sum;
                        hold[rcnt] <= bf_dif;
                        rcnt       <= rcnt + 1'b1;
                        if (rcnt == LAST_IDX) phase <= PH_DIFF;
                    end
                end
                default: begin
                    out_valid <= 1'b1;
                    out_q     <= hold[rcnt];
                    rcnt      <= rcnt + 1'b1;
                    if (rcnt == LAST_IDX) begin
                        out_last <= 1'b1;
                        phase    <= PH_SUM;
                    end
                end
            endcase
        end
    end

    assign out_re = out_q.re;
    assign out_im = out_q.im;

    // Output position counter, used only by the properties below
    logic [HALF_LOG:0] ocnt;
    always_ff @(posedge clk) begin
        if (rst) ocnt <= '0;
        else if (out_valid) ocnt <= ocnt + 1'b1;
    end

    assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid)
        else $error("last without valid");

    assert_last_pos_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (ocnt == {(HALF_LOG+1){1'b1}})))
        else $error("last flag misplaced");

    assert_diff_run_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DIFF) |=> out_valid)
        else $error("gap in difference run");

    assert_prod_range_R8: assert property (@(posedge clk) disable iff (rst)
        odd_acc |-> (($signed(prod.re) <= PROD_BOUND) && ($signed(prod.re) >= -PROD_BOUND) &&
                     ($signed(prod.im) <= PROD_BOUND) && ($signed(prod.im) >= -PROD_BOUND)))
        else $error("twiddle product out of range");

endmodule

// File: tb/fft16_last_stage_tb.sv
`timescale 1ns/1ps
module fft16_last_stage_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               even_valid = 1'b0;
    logic               even_ready;
    logic signed [15:0] even_re = '0;
    logic signed [15:0] even_im = '0;
    logic               odd_valid = 1'b0;
    logic               odd_ready;
    logic signed [15:0] odd_re = '0;
    logic signed [15:0] odd_im = '0;
    logic               out_valid;
    logic               out_last;
    logic signed [17:0] out_re;
    logic signed [17:0] out_im;

    always #10 clk = ~clk;

    fft16_last_stage u_dut (
        .clk(clk), .rst(rst),
        .even_valid(even_valid), .even_ready(even_ready), .even_re(even_re), .even_im(even_im),
        .odd_valid(odd_valid), .odd_ready(odd_ready), .odd_re(odd_re), .odd_im(odd_im),
        .out_valid(out_valid), .out_last(out_last), .out_re(out_re), .out_im(out_im)
    );

    typedef struct {
        longint re;
        longint im;
        bit     last;
        int     idx;
    } exp_t;

    exp_t   expq[$];
    int     n_checks = 0;
    int     n_errors = 0;
    bit     done = 0;
    logic [31:0] seed = 32'h1234_5678;

    int e_re [4][8];
    int e_im [4][8];
    int o_re [4][8];
    int o_im [4][8];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int flip3(input int v);
        return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
    endfunction

    function automatic int next_val();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[31:16]));
    endfunction

    task automatic fill_random(input int s);
        for (int k = 0; k < 8; k++) begin
            e_re[s][k] = next_val(); e_im[s][k] = next_val();
            o_re[s][k] = next_val(); o_im[s][k] = next_val();
        end
    endtask

    task automatic push_expected(input int s);
        longint dr [8];
        longint di [8];
        for (int k = 0; k < 8; k++) begin
            real    ang;
            longint wr, wi, pr, pi;
            exp_t   it;
            ang = 2.0 * 3.14159265358979 * k / 16.0;
            wr  = longint'(int'($cos(ang) * 16384.0));
            wi  = longint'(int'(-$sin(ang) * 16384.0));
            pr  = (longint'(o_re[s][k]) * wr - longint'(o_im[s][k]) * wi + 8192) >>> 14;
            pi  = (longint'(o_re[s][k]) * wi + longint'(o_im[s][k]) * wr + 8192) >>> 14;
            it.re = e_re[s][k] + pr; it.im = e_im[s][k] + pi;
            it.last = 1'b0; it.idx = k;
            expq.push_back(it);
            dr[k] = e_re[s][k] - pr; di[k] = e_im[s][k] - pi;
        end
        for (int k = 0; k < 8; k++) begin
            exp_t it;
            it.re = dr[k]; it.im = di[k]; it.last = (k == 7); it.idx = k + 8;
            expq.push_back(it);
        end
    endtask

    // Beats go out in bit-reversed bin order (R2)
    task automatic send_even(input int s, input int from, input int upto);
        for (int j = from; j <= upto; j++) begin
            @(negedge clk);
            even_valid = 1'b1;
            even_re = 16'(e_re[s][flip3(j)]);
            even_im = 16'(e_im[s][flip3(j)]);
            while (!even_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        even_valid = 1'b0;
    endtask

    task automatic send_odd(input int s);
        push_expected(s);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            odd_valid = 1'b1;
            odd_re = 16'(o_re[s][k]);
            odd_im = 16'(o_im[s][k]);
            while (!odd_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        odd_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4", "unexpected output", longint'(out_re), 0);
            end else begin
                exp_t  it;
                string tag;
                it  = expq.pop_front();
                tag = (it.idx < 8) ? "R2 R3" : "R4";
                check(longint'(out_re) == it.re && longint'(out_im) == it.im, tag,
                      $sformatf("bin %0d re (im act %0d exp %0d)", it.idx, out_im, it.im),
                      longint'(out_re), it.re);
                check(out_last == it.last, "R5", $sformatf("last flag bin %0d", it.idx),
                      longint'(out_last), longint'(it.last));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: state during and after reset
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        do_reset();
        check(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
        check(even_ready == 1'b1, "R1", "even_ready", longint'(even_ready), 1);
        check(odd_ready == 1'b0, "R1", "odd_ready", longint'(odd_ready), 0);

        // R6: odd side gated until eight even beats are in
        fill_random(0);
        send_even(0, 0, 6);
        check(odd_ready == 1'b0, "R6", "odd_ready after 7 beats", longint'(odd_ready), 0);
        send_even(0, 7, 7);
        check(odd_ready == 1'b1, "R6", "odd_ready after 8 beats", longint'(odd_ready), 1);
        send_odd(0);
        drain();

        // R7: two frames stored, third blocked, capture overlaps combining
        fill_random(1);
        for (int k = 0; k < 8; k++) begin
            e_re[2][k] = k * 1000 - 3000;
            e_im[2][k] = 500 - k * 250;
            o_re[2][k] = (k == 3) ? 8000 : 0;
            o_im[2][k] = (k == 5) ? -7000 : 0;
        end
        for (int k = 0; k < 8; k++) begin
            // R8: full-scale values
            e_re[3][k] = (k % 2 == 0) ? -32768 : 32767;
            e_im[3][k] = (k % 2 == 0) ? 32767 : -32768;
            o_re[3][k] = (k % 2 == 0) ? -32768 : 32767;
            o_im[3][k] = -32768;
        end
        send_even(1, 0, 7);
        send_even(2, 0, 7);
        check(even_ready == 1'b0, "R7", "even_ready with two frames held", longint'(even_ready), 0);
        fork
            send_odd(1);
            send_even(3, 0, 7);
        join
        send_odd(2);
        send_odd(3);
        drain();
        check(even_ready == 1'b1, "R7", "even_ready after all frames consumed", longint'(even_ready), 1);

        // R9: partial frame discarded by reset
        fill_random(0);
        send_even(0, 0, 4);
        do_reset();
        check(even_ready == 1'b1, "R9", "even_ready after reset", longint'(even_ready), 1);
        check(odd_ready == 1'b0, "R9", "odd_ready after reset", longint'(odd_ready), 0);
        fill_random(1);
        send_even(1, 0, 6);
        check(odd_ready == 1'b0, "R9", "odd_ready after 7 fresh beats", longint'(odd_ready), 0);
        send_even(1, 7, 7);
        send_odd(1);
        drain();

        check(expq.size() == 0, "R4", "outputs outstanding", longint'(expq.size()), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule